// File: doc/BRIEF.md
# Burst-Data Nibble Inserter with Lock Gating

This block sits at the output of a video digitizer. It carries a subcarrier loop's frequency word, phase word and field identity to the next chip, with no extra pins. While the horizontal sync-tip window input is high, it replaces the video samples with 4-bit nibbles on the low four bits of the video bus, one nibble per pixel clock. While the window is low, it passes the video samples through unchanged. Both paths have the same single-register latency, so downstream logic sees one aligned stream.

The block also gates the regenerated sync outputs according to a lock flag. While unlocked, vertical sync is held off, and every eighth horizontal sync pulse is removed. Lines are counted from the last vertical sync. The nibble stream keeps running while unlocked, but the frequency it reports is a default word picked by a format selector. Loop arithmetic, sync detection and lock acquisition happen elsewhere. Their results arrive here as inputs.

Top module: `burst_nibble_inserter`

## Requirements
- R1: While `tip_win` was low at a clock edge, `vid_out` after that edge equals the `vid_in` value sampled at that edge (one register of latency).
- R2: While `tip_win` was high at a clock edge, the upper bits `vid_out[VID_W-1:4]` after that edge are zero, and a new nibble is placed on `vid_out[3:0]` at every edge of the window.
- R3: A window emits, in order: the frequency word's nibbles from most significant to least, then the phase word's nibbles from most significant to least, then one nibble holding the field identity in its low bits with zeros above. After that last nibble, `vid_out[3:0]` stays 0 until the window closes.
- R4: Frequency, phase and field identity are captured at the first clock of a window (`tip_win` high after a low cycle). Input changes later in the same window do not alter the nibbles sent.
- R5: If `lock` is low at the first clock of a window, the frequency nibbles come from a default word chosen by `fmt_sel`. The defaults are 0=16'h21F0, 1=16'h2A09, 2=16'h1C84 and 3=16'h2A1B. Phase and field identity are sent as usual.
- R6: `vsync_out` is `vsync_in & lock`, registered once.
- R7: Horizontal sync pulses are numbered from 0 at each rising edge of `vsync_in`, counting modulo 8. While `lock` is low, a pulse whose number is 7 is held low at `hsync_out`. Every other pulse, and every pulse while locked, appears at `hsync_out` one clock late.
- R8: Pulse numbering continues while locked, so a pulse numbered 7 that arrives after the lock is lost is still suppressed.
- R9: A new window always restarts the sequence at the first frequency nibble.
- R10: During reset, `vid_out`, `hsync_out` and `vsync_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_in | input | VID_W | Digitized video samples |
| tip_win | input | 1 | High during the horizontal sync-tip interval |
| lock | input | 1 | Subcarrier/line lock status |
| fmt_sel | input | $clog2(FMT_CNT) | Format selector for the default frequency word |
| freq_in | input | FREQ_W | Subcarrier frequency word from the loop |
| phase_in | input | PHASE_W | Subcarrier phase word from the loop |
| field_in | input | FIELD_W | Field identity |
| hsync_in | input | 1 | Regenerated horizontal sync |
| vsync_in | input | 1 | Regenerated vertical sync |
| vid_out | output | VID_W | Video samples or inserted nibbles |
| hsync_out | output | 1 | Gated horizontal sync |
| vsync_out | output | 1 | Gated vertical sync |

## Verification
A wrong nibble index or a stale snapshot shows at the ports within the same window. It appears as a nibble out of order, a nibble repeated, or a wrong value on `vid_out[3:0]` one clock after the faulty edge, and it recurs on every later line. A line counter that is off by one, or that is not cleared at vertical sync, is only visible while unlocked. In that case the missing horizontal pulse lands on the wrong line, within eight lines of the last vertical sync. A wrong output select shows immediately as live video leaking into the window, or as nibbles appearing outside it.

// File: rtl/bni_pkg.sv
package bni_pkg;
   localparam int NIB_W = 4;
   typedef logic [NIB_W-1:0] nib_t;

   function automatic int nib_count(input int bits);
      return (bits + NIB_W - 1) / NIB_W;
   endfunction
endpackage

// File: rtl/bni_serializer.sv
module bni_serializer
   import bni_pkg::*;
#(
   parameter int FREQ_W  = 16,
   parameter int PHASE_W = 8,
   parameter int FIELD_W = 2,
   parameter int FMT_CNT = 4,
   parameter logic [FREQ_W-1:0] FMT_DEF [FMT_CNT] = '{16'h21F0, 16'h2A09, 16'h1C84, 16'h2A1B}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tip,
   input  logic                       lock,
   input  logic [$clog2(FMT_CNT)-1:0] fmt_sel,
   input  logic [FREQ_W-1:0]          freq,
   input  logic [PHASE_W-1:0]         phase,
   input  logic [FIELD_W-1:0]         field,
   output nib_t                       nib
);
   localparam int FN     = FREQ_W / NIB_W;
   localparam int PN     = PHASE_W / NIB_W;
   localparam int NIBS   = FN + PN + 1;
   localparam int PK_W   = NIBS * NIB_W;
   localparam int IDX_W  = $clog2(NIBS + 1);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NIBS);

   if (FREQ_W % NIB_W != 0) begin : g_bad_freq
      $error("FREQ_W must be a multiple of 4");
   end
   if (PHASE_W % NIB_W != 0) begin : g_bad_phase
      $error("PHASE_W must be a multiple of 4");
   end
   if (FIELD_W < 1 || FIELD_W > NIB_W) begin : g_bad_field
      $error("FIELD_W must be 1..4");
   end

   nib_t                field_nib;
   logic [FREQ_W-1:0]   freq_eff;
   logic [PK_W-1:0]     live, word_q, src;
   logic [IDX_W-1:0]    idx_q, idx;
   logic                tip_d, start;
   nib_t                nib_arr [NIBS];

   if (FIELD_W == NIB_W) begin : g_field_full
      assign field_nib = field;
   end else begin : g_field_pad
      assign field_nib = {{(NIB_W-FIELD_W){1'b0}}, field};
   end

   assign freq_eff = lock ? freq : FMT_DEF[fmt_sel];
   assign live     = {freq_eff, phase, field_nib};
   assign start    = tip & ~tip_d;
   assign src      = start ? live : word_q;
   assign idx      = start ? '0 : idx_q;

   for (genvar g = 0; g < NIBS; g++) begin : g_nib
      assign nib_arr[g] = src[PK_W-1-NIB_W*g -: NIB_W];
   end

   always_comb begin
      nib = '0;
      for (int k = 0; k < NIBS; k++) begin
         if (idx == IDX_W'(k)) nib = nib_arr[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tip_d  <= 1'b0;
         word_q <= '0;
         idx_q  <= '0;
      end else begin
         tip_d <= tip;
         if (start) begin
            word_q <= live;
            idx_q  <= IDX_W'(1);
         end else if (tip && idx_q < LAST) begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end
endmodule

// File: rtl/bni_sync_gate.sv
module bni_sync_gate #(
   parameter int GATE_PERIOD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock,
   input  logic hs_in,
   input  logic vs_in,
   output logic hs_out,
   output logic vs_out
);
   localparam int LINE_W = $clog2(GATE_PERIOD);
   localparam logic [LINE_W-1:0] SLOT = LINE_W'(GATE_PERIOD - 1);

   if (GATE_PERIOD < 2 || (GATE_PERIOD & (GATE_PERIOD - 1)) != 0) begin : g_bad_period
      $error("GATE_PERIOD must be a power of two >= 2");
   end

   logic [LINE_W-1:0] line_q;
   logic              hs_d, vs_d, slot_q, slot;
   logic              hs_rise, vs_rise;

   assign hs_rise = hs_in & ~hs_d;
   assign vs_rise = vs_in & ~vs_d;
   assign slot    = hs_rise ? (line_q == SLOT) : slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_d   <= 1'b0;
         vs_d   <= 1'b0;
         slot_q <= 1'b0;
         line_q <= '0;
         hs_out <= 1'b0;
         vs_out <= 1'b0;
      end else begin
         hs_d   <= hs_in;
         vs_d   <= vs_in;
         slot_q <= slot;
         if (vs_rise)      line_q <= '0;
         else if (hs_rise) line_q <= line_q + LINE_W'(1);
         hs_out <= hs_in & (lock | ~slot);
         vs_out <= vs_in & lock;
      end
   end
endmodule

// File: rtl/burst_nibble_inserter.sv
module burst_nibble_inserter
   import bni_pkg::*;
#(
   parameter int VID_W       = 8,
   parameter int FREQ_W      = 16,
   parameter int PHASE_W     = 8,
   parameter int FIELD_W     = 2,
   parameter int FMT_CNT     = 4,
   parameter int GATE_PERIOD = 8,
   parameter logic [FREQ_W-1:0] FMT_DEF [FMT_CNT] = '{16'h21F0, 16'h2A09, 16'h1C84, 16'h2A1B}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [VID_W-1:0]           vid_in,
   input  logic                       tip_win,
   input  logic                       lock,
   input  logic [$clog2(FMT_CNT)-1:0] fmt_sel,
   input  logic [FREQ_W-1:0]          freq_in,
   input  logic [PHASE_W-1:0]         phase_in,
   input  logic [FIELD_W-1:0]         field_in,
   input  logic                       hsync_in,
   input  logic                       vsync_in,
   output logic [VID_W-1:0]           vid_out,
   output logic                       hsync_out,
   output logic                       vsync_out
);
   if (VID_W <= NIB_W) begin : g_bad_vid
      $error("VID_W must exceed 4");
   end
   if (FMT_CNT < 2) begin : g_bad_fmt
      $error("FMT_CNT must be at least 2");
   end

   nib_t nib;

   bni_serializer #(
      .FREQ_W (FREQ_W),
      .PHASE_W(PHASE_W),
      .FIELD_W(FIELD_W),
      .FMT_CNT(FMT_CNT),
      .FMT_DEF(FMT_DEF)
   ) u_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .tip    (tip_win),
      .lock   (lock),
      .fmt_sel(fmt_sel),
      .freq   (freq_in),
      .phase  (phase_in),
      .field  (field_in),
      .nib    (nib)
   );

   bni_sync_gate #(
      .GATE_PERIOD(GATE_PERIOD)
   ) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .lock  (lock),
      .hs_in (hsync_in),
      .vs_in (vsync_in),
      .hs_out(hsync_out),
      .vs_out(vsync_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vid_out <= '0;
      else        vid_out <= tip_win ? {{(VID_W-NIB_W){1'b0}}, nib} : vid_in;
   end
endmodule

// File: rtl/bni_checker.sv
module bni_checker #(
   parameter int VID_W  = 8,
   parameter int FREQ_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [VID_W-1:0]  vid_in,
   input logic              tip_win,
   input logic              lock,
   input logic [FREQ_W-1:0] freq_in,
   input logic              hsync_in,
   input logic              vsync_in,
   input logic [VID_W-1:0]  vid_out,
   input logic              hsync_out,
   input logic              vsync_out
);
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && !$past(tip_win)) |-> vid_out == $past(vid_in));

   assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && $past(tip_win)) |-> vid_out[VID_W-1:4] == '0);

   assert_first_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2 && $past(tip_win) && !$past(tip_win, 2) && $past(lock))
      |-> vid_out[3:0] == $past(freq_in[FREQ_W-1 -: 4]));

   assert_vsync_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && vsync_out) |-> ($past(lock) && $past(vsync_in)));

   assert_hsync_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && hsync_out) |-> $past(hsync_in));

   assert_hsync_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0 && $past(lock)) |-> hsync_out == $past(hsync_in));
endmodule

bind burst_nibble_inserter bni_checker #(
   .VID_W (VID_W),
   .FREQ_W(FREQ_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .vid_in   (vid_in),
   .tip_win  (tip_win),
   .lock     (lock),
   .freq_in  (freq_in),
   .hsync_in (hsync_in),
   .vsync_in (vsync_in),
   .vid_out  (vid_out),
   .hsync_out(hsync_out),
   .vsync_out(vsync_out)
);

// File: tb/burst_nibble_inserter_tb.sv
module burst_nibble_inserter_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] vid_in = 8'h00;
   logic       tip_win = 1'b0;
   logic       lock = 1'b1;
   logic [1:0] fmt_sel = 2'd0;
   logic [15:0] freq_in = 16'h1234;
   logic [7:0] phase_in = 8'h5A;
   logic [1:0] field_in = 2'b10;
   logic       hsync_in = 1'b0;
   logic       vsync_in = 1'b0;
   logic [7:0] vid_out;
   logic       hsync_out, vsync_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   burst_nibble_inserter u_dut (
      .clk(clk), .rst_n(rst_n), .vid_in(vid_in), .tip_win(tip_win), .lock(lock),
      .fmt_sel(fmt_sel), .freq_in(freq_in), .phase_in(phase_in), .field_in(field_in),
      .hsync_in(hsync_in), .vsync_in(vsync_in), .vid_out(vid_out),
      .hsync_out(hsync_out), .vsync_out(vsync_out)
   );

   // {tip, vid_in, expected vid_out one clock later}; freq 1234, phase 5A, field 2
   localparam logic [16:0] VEC [13] = '{
      {1'b0, 8'h3C, 8'h3C}, {1'b1, 8'hFF, 8'h01}, {1'b1, 8'hFF, 8'h02},
      {1'b1, 8'hFF, 8'h03}, {1'b1, 8'hFF, 8'h04}, {1'b1, 8'hFF, 8'h05},
      {1'b1, 8'hFF, 8'h0A}, {1'b1, 8'hFF, 8'h02}, {1'b1, 8'hEE, 8'h00},
      {1'b0, 8'h81, 8'h81}, {1'b1, 8'h77, 8'h01}, {1'b1, 8'h77, 8'h02},
      {1'b0, 8'h10, 8'h10}
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
      end
   end

   initial begin
      vid_in = 8'hA5;
      hsync_in = 1'b1;
      vsync_in = 1'b1;
      repeat (3) @(negedge clk);
      // R10: outputs zero in reset
      check(vid_out, 8'h00, "R10 vid");
      check({7'd0, hsync_out}, 8'h00, "R10 hsync");
      check({7'd0, vsync_out}, 8'h00, "R10 vsync");
      hsync_in = 1'b0;
      vsync_in = 1'b0;
      rst_n = 1'b1;
      tick();

      // R1 R2 R3 R9: vector walk
      foreach (VEC[i]) begin
         tip_win = VEC[i][16];
         vid_in  = VEC[i][15:8];
         tick();
         check(vid_out, VEC[i][7:0], "R1/R2/R3/R9 vector");
      end

      // R4: snapshot at window start
      tip_win = 1'b0; tick();
      tip_win = 1'b1; tick();
      check(vid_out, 8'h01, "R4 first");
      freq_in = 16'hFFFF; phase_in = 8'h00;
      tick(); check(vid_out, 8'h02, "R4 held");
      tick(); check(vid_out, 8'h03, "R4 held");
      tick(); tick(); check(vid_out, 8'h05, "R4 phase held");
      tip_win = 1'b0; freq_in = 16'h1234; phase_in = 8'h5A; tick();

      // R5: unlocked default word for fmt 2 = 1C84
      lock = 1'b0; fmt_sel = 2'd2;
      tip_win = 1'b1; tick(); check(vid_out, 8'h01, "R5 n0");
      tick(); check(vid_out, 8'h0C, "R5 n1");
      tick(); check(vid_out, 8'h08, "R5 n2");
      tick(); check(vid_out, 8'h04, "R5 n3");
      tick(); check(vid_out, 8'h05, "R5 phase");
      tick(); tick(); check(vid_out, 8'h02, "R5 field");
      tip_win = 1'b0; tick();

      // R6: vsync gating
      lock = 1'b1; vsync_in = 1'b1; tick();
      check({7'd0, vsync_out}, 8'h01, "R6 locked");
      lock = 1'b0; tick();
      check({7'd0, vsync_out}, 8'h00, "R6 unlocked");
      vsync_in = 1'b0; tick();

      // R7: unlocked, vsync edge clears count, 16 pulses
      vsync_in = 1'b1; tick(); vsync_in = 1'b0; tick();
      for (int k = 0; k < 16; k++) begin
         hsync_in = 1'b1; tick();
         check({7'd0, hsync_out}, {7'd0, (k % 8) != 7}, "R7 unlocked pulse");
         tick();
         check({7'd0, hsync_out}, {7'd0, (k % 8) != 7}, "R7 unlocked held");
         hsync_in = 1'b0; tick(); tick();
      end

      // R7 locked: pulse 7 passes; R8: counting continues while locked
      lock = 1'b1;
      vsync_in = 1'b1; tick(); vsync_in = 1'b0; tick();
      for (int k = 0; k < 8; k++) begin
         hsync_in = 1'b1; tick();
         check({7'd0, hsync_out}, 8'h01, "R7 locked pulse");
         hsync_in = 1'b0; tick(); tick();
      end
      vsync_in = 1'b1; tick(); vsync_in = 1'b0; tick();
      for (int k = 0; k < 7; k++) begin
         hsync_in = 1'b1; tick(); hsync_in = 1'b0; tick(); tick();
      end
      lock = 1'b0;
      hsync_in = 1'b1; tick();
      check({7'd0, hsync_out}, 8'h00, "R8 pulse 7 after lock loss");
      hsync_in = 1'b0; tick(); tick();
      hsync_in = 1'b1; tick();
      check({7'd0, hsync_out}, 8'h01, "R8 pulse 0 passes");
      hsync_in = 1'b0; tick();

      done = 1'b1;
      summary();
   end
endmodule